// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Unit

This unit drives the fine-tuning mode of a multi-channel digital potentiometer controller. The command decoder acknowledges an up/down stepping instruction and then hands control to this unit with a one-cycle start pulse and the number of the target wiper. From then on, the unit does not treat the data line as serial data. It reads the data line as a direction level on every rising edge of the serial clock. A high level asks for one step toward the high terminal. A low level asks for one step toward the low terminal. Up and down steps may be mixed freely, and there is no limit on how many are issued.

The unit sends its requests to the wiper register bank as single-cycle pulses, together with a direction and the selected wiper. It reads back the current position of the selected wiper so that it issues no request past either end of the range. The mode ends when the bus detector reports a STOP or a START condition. While the mode is active the unit assembles no bytes and drives no acknowledge.

Top module: `wiper_step_unit`

## Requirements
- R1: After reset `active` is 0 and `step_req` is 0.
- R2: A `cmd_go` pulse sets `active` at the next clock edge and latches `cmd_pot`, which then appears on `step_pot`. A further `cmd_go` while active re-selects the wiper.
- R3: While active, each cycle in which `scl_s` is 1 and was 0 in the previous cycle produces a one-cycle `step_req` in the following cycle, with `step_up` = 1 when `sda_s` was 1 in that cycle.
- R4: A rising edge sampled with `sda_s` = 0 produces a request with `step_up` = 0. Any sequence of up and down steps moves the wiper by the number of ups minus the number of downs.
- R5: Exactly one request is issued per rising edge. Holding `scl_s` high, falling edges, and changes of `sda_s` while `scl_s` is high produce no request.
- R6: No up request is issued while `sel_pos` equals 2^POS_W-1 (255 by default). No down request is issued while `sel_pos` is 0. The position saturates and does not wrap.
- R7: A `stop_det` pulse clears `active` at the next edge. Later clock edges produce no request.
- R8: A `start_det` pulse also clears `active`. Later clock edges produce no request.
- R9: Termination dominates. A rising edge in the same cycle as `stop_det` or `start_det` produces no request. A `cmd_go` in the same cycle as a termination pulse leaves `active` at 0.
- R10: While `active` is 0, clock edges produce no request, whatever the level of `sda_s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronised serial clock level |
| sda_s | input | 1 | Synchronised serial data level, used as the step direction |
| cmd_go | input | 1 | Pulse from the decoder: stepping instruction acknowledged |
| cmd_pot | input | POT_W | Wiper selected by the instruction |
| stop_det | input | 1 | Pulse: STOP condition seen on the bus |
| start_det | input | 1 | Pulse: START condition seen on the bus |
| sel_pos | input | POS_W | Current position of the selected wiper, from the register bank |
| active | output | 1 | Stepping mode is in force |
| step_req | output | 1 | One-cycle request to step the selected wiper |
| step_up | output | 1 | Direction of the request: 1 toward high, 0 toward low |
| step_pot | output | POT_W | Wiper that the request addresses |

## Verification
Two events can fall in the same cycle: a clock rising edge that asks for a step, and a termination pulse that ends the mode. A `cmd_go` can also coincide with a termination pulse. The bench raises `scl_s` and pulses `stop_det` on the same drive edge. It then checks that the bench's own model of the register bank has not moved, that no request was counted, and that `active` has dropped. It does the same for `cmd_go` together with `stop_det`, and checks that the mode never starts.

// File: rtl/wiper_step_unit.sv
module wiper_step_unit #(
  parameter int POS_W = 8,
  parameter int POT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             cmd_go,
  input  logic [POT_W-1:0] cmd_pot,
  input  logic             stop_det,
  input  logic             start_det,
  input  logic [POS_W-1:0] sel_pos,
  output logic             active,
  output logic             step_req,
  output logic             step_up,
  output logic [POT_W-1:0] step_pot
);
  localparam logic [POS_W-1:0] POS_TOP = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_BOT = '0;

  logic             scl_q;
  logic             active_q;
  logic [POT_W-1:0] pot_q;
  logic             req_q;
  logic             up_q;

  wire term    = stop_det | start_det;
  wire scl_up  = scl_s & ~scl_q;
  wire at_edge = (sda_s && sel_pos == POS_TOP) || (!sda_s && sel_pos == POS_BOT);
  wire fire    = active_q & scl_up & ~term & ~at_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b0;
      active_q <= 1'b0;
      pot_q    <= '0;
      req_q    <= 1'b0;
      up_q     <= 1'b0;
    end else begin
      scl_q <= scl_s;
      if (term)        active_q <= 1'b0;
      else if (cmd_go) active_q <= 1'b1;
      if (cmd_go && !term) pot_q <= cmd_pot;
      req_q <= fire;
      if (fire) up_q <= sda_s;
    end
  end

  assign active   = active_q;
  assign step_req = req_q;
  assign step_up  = up_q;
  assign step_pot = pot_q;
endmodule

// File: rtl/wiper_step_unit_chk.sv
module wiper_step_unit_chk #(
  parameter int POS_W = 8,
  parameter int POT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_s,
  input logic             cmd_go,
  input logic [POT_W-1:0] cmd_pot,
  input logic             stop_det,
  input logic             start_det,
  input logic [POS_W-1:0] sel_pos,
  input logic             active,
  input logic             step_req,
  input logic             step_up,
  input logic [POT_W-1:0] step_pot
);
  localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

  p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !stop_det && !start_det) |=> (active && step_pot == $past(cmd_pot)));

  p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> (step_up == $past(sda_s) && $rose($past(scl_s))));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |=> !step_req);

  p_no_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && step_up) |-> $past(sel_pos) != TOP);

  p_no_wrap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_up) |-> $past(sel_pos) != '0);

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || start_det) |=> (!active && !step_req));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step_req |-> $past(active));
endmodule

bind wiper_step_unit wiper_step_unit_chk #(.POS_W(POS_W), .POT_W(POT_W)) chk_i (.*);

// File: tb/wiper_step_unit_tb_top.sv
module wiper_step_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_s = 1'b0, sda_s = 1'b0, cmd_go = 1'b0, stop_det = 1'b0, start_det = 1'b0;
  logic [1:0] cmd_pot = '0;
  logic [7:0] sel_pos;
  logic       active, step_req, step_up;
  logic [1:0] step_pot;

  logic [7:0] bank [4];
  logic       ld = 1'b0;
  logic [1:0] ld_idx = '0;
  logic [7:0] ld_val = '0;
  int         nreq = 0;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  wiper_step_unit dut_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .cmd_go(cmd_go),
    .cmd_pot(cmd_pot), .stop_det(stop_det), .start_det(start_det), .sel_pos(sel_pos),
    .active(active), .step_req(step_req), .step_up(step_up), .step_pot(step_pot)
  );

  assign sel_pos = bank[step_pot];

  always @(posedge clk) begin
    if (ld) bank[ld_idx] <= ld_val;
    else if (step_req) begin
      bank[step_pot] <= step_up ? bank[step_pot] + 8'd1 : bank[step_pot] - 8'd1;
      nreq <= nreq + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int idx, int val);
    @(negedge clk); ld = 1'b1; ld_idx = idx[1:0]; ld_val = val[7:0];
    @(negedge clk); ld = 1'b0;
  endtask

  task automatic cmd(int pot);
    @(negedge clk); cmd_go = 1'b1; cmd_pot = pot[1:0];
    @(negedge clk); cmd_go = 1'b0;
  endtask

  task automatic pulse(bit d);
    @(negedge clk); scl_s = 1'b1; sda_s = d;
    repeat (3) @(negedge clk);
    scl_s = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic end_mode(bit use_start);
    @(negedge clk); if (use_start) start_det = 1'b1; else stop_det = 1'b1;
    @(negedge clk); start_det = 1'b0; stop_det = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", active, 0);
    check("R1 step_req", step_req, 0);
  endtask

  task automatic t_idle();
    int n0 = nreq;
    load(0, 40);
    pulse(1); pulse(0); pulse(1);
    check("R10 requests", nreq - n0, 0);
    check("R10 bank0", bank[0], 40);
  endtask

  task automatic t_up_down();
    int n0;
    load(2, 100);
    cmd(2);
    check("R2 active", active, 1);
    check("R2 pot", step_pot, 2);
    n0 = nreq;
    pulse(1); pulse(1); pulse(1);
    check("R3 bank2 up", bank[2], 103);
    check("R3 requests", nreq - n0, 3);
    repeat (5) pulse(0);
    check("R4 bank2 down", bank[2], 98);
    pulse(1); pulse(0); pulse(1); pulse(1);
    check("R4 mixed", bank[2], 100);
  endtask

  task automatic t_hold();
    int n0 = nreq;
    @(negedge clk); scl_s = 1'b1; sda_s = 1'b1;
    repeat (4) @(negedge clk);
    sda_s = 1'b0;
    repeat (4) @(negedge clk);
    sda_s = 1'b1;
    repeat (4) @(negedge clk);
    scl_s = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 one request per edge", nreq - n0, 1);
    check("R5 bank2", bank[2], 101);
  endtask

  task automatic t_reselect_sat();
    int n0;
    load(1, 254);
    cmd(1);
    check("R2 reselect", step_pot, 1);
    n0 = nreq;
    pulse(1); pulse(1); pulse(1);
    check("R6 top sat", bank[1], 255);
    check("R6 top requests", nreq - n0, 1);
    pulse(0);
    check("R6 leave top", bank[1], 254);
    load(3, 1);
    cmd(3);
    pulse(0); pulse(0); pulse(0);
    check("R6 bottom sat", bank[3], 0);
    pulse(1);
    check("R6 leave bottom", bank[3], 1);
    check("R2 bank2 untouched", bank[2], 101);
  endtask

  task automatic t_stop();
    int n0;
    end_mode(0);
    check("R7 active", active, 0);
    n0 = nreq;
    pulse(1); pulse(0);
    check("R7 no step", nreq - n0, 0);
    check("R7 bank3", bank[3], 1);
  endtask

  task automatic t_start();
    int n0;
    load(0, 60);
    cmd(0);
    pulse(1);
    check("R8 step before", bank[0], 61);
    end_mode(1);
    check("R8 active", active, 0);
    n0 = nreq;
    pulse(1);
    check("R8 no step", nreq - n0, 0);
  endtask

  task automatic t_collide();
    int n0;
    load(0, 50);
    cmd(0);
    n0 = nreq;
    @(negedge clk); scl_s = 1'b1; sda_s = 1'b1; stop_det = 1'b1;
    @(negedge clk); stop_det = 1'b0;
    repeat (3) @(negedge clk);
    scl_s = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 edge with stop", nreq - n0, 0);
    check("R9 bank0", bank[0], 50);
    check("R9 active after", active, 0);
    @(negedge clk); cmd_go = 1'b1; cmd_pot = 2'd0; stop_det = 1'b1;
    @(negedge clk); cmd_go = 1'b0; stop_det = 1'b0;
    check("R9 go with stop", active, 0);
    pulse(1);
    check("R9 no step after", bank[0], 50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_up_down();
    t_hold();
    t_reselect_sat();
    t_stop();
    t_start();
    t_collide();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule